// File: doc/BRIEF.md
# Shared-Memory CPU Wait-State Generator

This block produces the active-low wait request for an 8-bit CPU whose memory is shared with a video controller. On the first cycle of each bus cycle it takes the bus cycle's kind and address. Two kinds of access are stretched.

Memory outside the video pages gets a short fixed stretch. Whether that stretch applies depends on a software-chosen wait mode and on whether the access is an opcode fetch. Accesses to pages flagged as video memory, and I/O accesses to the video controller's ports, are held until the CPU's next access slot. The video timing is split into repeating 16-cycle windows. The CPU owns the first six cycles of each window, and the video fetches own the remaining ten. The CPU is released exactly at a window boundary.

A free-running horizontal position counter tracks the video timing. It runs over a 912-cycle scan line. Because 912 is a whole number of windows, the window phase stays continuous across line wraps. The integrator drives the start strobe, kind, address, page flags and mode, and connects the wait output to the CPU's wait pin.

Top module: `wsg_top`

## Requirements
- R1: Bits 15:14 of the address select one of four 16 KiB pages. If bit p of `vpage_mask` is set for the selected page p, memory reads, writes and opcode fetches to that page are video accesses, with the stall timing of R6.
- R2: `wait_mode` is decoded as follows. 0 means no fixed waits. 1 means waits on opcode fetches only. 2 means waits on every memory access. Value 3 behaves exactly like 2.
- R3: A non-video memory read (`cyc_kind`=0) or write (`cyc_kind`=1) pulls `wait_n` low for exactly 2 cycles, but only when the mode is 2 or 3. Otherwise it causes no wait.
- R4: A non-video opcode fetch (`cyc_kind`=2) pulls `wait_n` low for exactly 2 cycles in every mode except 0.
- R5: A fixed stall is placed at the opening of the bus cycle. `wait_n` is low in the two cycles directly after the cycle in which `cyc_start` was sampled.
- R6: A video stall is placed at the end of the bus cycle. Let cycle s be the one in which `cyc_start` was sampled. From cycle s+3, `wait_n` stays low until the window phase (horizontal position mod 16) returns to 0. The length is 15 XOR ((p+15) mod 16), where p is the phase at s+3. So phase 0 gives no wait, phase 1 gives 15 cycles, and phase 15 gives 1 cycle.
- R7: The horizontal position is 0 in the first cycle after reset. It advances once per cycle and wraps from 911 to 0.
- R8: An I/O access (`cyc_kind`=3) whose address bits 7:4 equal 4'h8 is a video-controller port access and is stalled as in R6. Any other I/O access never causes a wait, whatever the mode or page flags.
- R9: A `cyc_start` that arrives while a stall is pending or in progress is ignored. The current stall keeps its timing, and no second stall follows.
- R10: During and directly after reset `wait_n` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one tick per half CPU cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_start | input | 1 | High in the first cycle of a bus cycle |
| cyc_kind | input | 2 | Bus cycle kind: 0 read, 1 write, 2 opcode fetch, 3 I/O |
| cyc_addr | input | 16 | Bus address |
| vpage_mask | input | 4 | One flag per 16 KiB page marking it as video memory |
| wait_mode | input | 2 | Fixed-wait mode, encoded as in R2 |
| wait_n | output | 1 | Active-low wait request to the CPU |

## Verification
On every cycle the assertions check several things. The position counter must step by one and stay within the line. Every video stall must release exactly on a window boundary. A fixed stall must never count beyond its two-cycle length. A start that arrives during a stall must leave the running countdown alone, and the lead-in before a video stall must not assert the wait. Only the bench's scenarios can show the rest. These cover the exact decode of kind, mode, page flag and port nibble into "no wait", "fixed wait" or "video wait", where each stall starts relative to its strobe, and the stall length at the chosen window phases, including after a line wrap.

// File: rtl/wsg_pkg.sv
package wsg_pkg;

  typedef enum logic [1:0] {
    K_MRD = 2'd0,
    K_MWR = 2'd1,
    K_OPF = 2'd2,
    K_IO  = 2'd3
  } bus_kind_t;

  typedef enum logic [1:0] {
    M_NONE = 2'd0,
    M_OPF  = 2'd1,
    M_ALL  = 2'd2,
    M_ALLX = 2'd3
  } wmode_t;

  // Cycles from window phase ph until the next window start (power-of-two win).
  function automatic int unsigned slot_dist(int unsigned win, int unsigned ph);
    int unsigned m;
    m = win - 1;
    return m ^ ((ph + m) & m);
  endfunction

  // Fixed stretch for a non-video access of the given kind under the given mode.
  function automatic int unsigned fixed_len(logic [1:0] kind, logic [1:0] mode,
                                            int unsigned pen);
    int unsigned r;
    r = 0;
    case (kind)
      K_MRD, K_MWR: if (mode[1]) r = pen;
      K_OPF:        if (mode != M_NONE) r = pen;
      default:      r = 0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/wsg_hcount.sv
module wsg_hcount #(
  parameter int LINE_LEN = 912,
  parameter int WIN      = 16,
  localparam int HW = $clog2(LINE_LEN),
  localparam int WW = $clog2(WIN)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hpos,
  output logic [WW-1:0] phase
);

  logic [HW-1:0] hpos_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hpos_q <= '0;
    end else if (hpos_q == HW'(LINE_LEN - 1)) begin
      hpos_q <= '0;
    end else begin
      hpos_q <= hpos_q + HW'(1);
    end
  end

  assign hpos  = hpos_q;
  assign phase = hpos_q[WW-1:0];

endmodule

// File: rtl/wsg_classify.sv
module wsg_classify
  import wsg_pkg::*;
#(
  parameter int AW        = 16,
  parameter int PAGES     = 4,
  parameter int FIXED_PEN = 2,
  parameter int CW        = 4,
  parameter logic [3:0] IO_SEL = 4'h8,
  localparam int PW = $clog2(PAGES)
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  input  logic [PAGES-1:0] vmask,
  input  logic [1:0]    mode,
  output logic          is_vid,
  output logic [CW-1:0] fix_len
);

  logic [PAGES-1:0] page_hit;
  logic             vpage;
  logic             vport;
  logic             is_mem;
  logic             unused_addr_bits;

  for (genvar g = 0; g < PAGES; g++) begin : g_page
    assign page_hit[g] = (addr[AW-1 -: PW] == PW'(g)) & vmask[g];
  end

  assign vpage  = |page_hit;
  assign is_mem = (kind != K_IO);
  assign vport  = (kind == K_IO) && (addr[7:4] == IO_SEL);
  assign is_vid = (is_mem && vpage) || vport;

  always_comb begin
    if (is_vid) fix_len = '0;
    else        fix_len = CW'(fixed_len(kind, mode, FIXED_PEN));
  end

  assign unused_addr_bits = ^{addr[AW-PW-1:8], addr[3:0]};

endmodule

// File: rtl/wsg_stall_ctr.sv
module wsg_stall_ctr
  import wsg_pkg::*;
#(
  parameter int WIN  = 16,
  parameter int LEAD = 2,
  parameter int CW   = 4,
  localparam int WW  = $clog2(WIN),
  localparam int PRW = $clog2(LEAD + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           take,
  input  logic           take_vid,
  input  logic [CW-1:0]  fix_len,
  input  logic [WW-1:0]  phase,
  output logic [CW-1:0]  cnt,
  output logic [PRW-1:0] pre,
  output logic           vid_active,
  output logic           busy,
  output logic           wait_n
);

  logic [CW-1:0]  cnt_q;
  logic [PRW-1:0] pre_q;
  logic           vid_q;
  logic [CW-1:0]  slot_len;

  // Stall length seen from the cycle after the load edge.
  assign slot_len = CW'(slot_dist(WIN, 32'(phase) + 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pre_q <= '0;
      vid_q <= 1'b0;
    end else if (take) begin
      if (take_vid) begin
        pre_q <= PRW'(LEAD);
        vid_q <= 1'b1;
      end else begin
        cnt_q <= fix_len;
        vid_q <= 1'b0;
      end
    end else if (pre_q != '0) begin
      pre_q <= pre_q - PRW'(1);
      if (pre_q == PRW'(1)) cnt_q <= slot_len;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign cnt        = cnt_q;
  assign pre        = pre_q;
  assign vid_active = vid_q;
  assign busy       = (cnt_q != '0) || (pre_q != '0);
  assign wait_n     = (cnt_q == '0);

endmodule

// File: rtl/wsg_top.sv
module wsg_top
  import wsg_pkg::*;
#(
  parameter int LINE_LEN  = 912,
  parameter int WIN       = 16,
  parameter int FIXED_PEN = 2,
  parameter int LEAD      = 2,
  parameter int AW        = 16,
  parameter int PAGES     = 4,
  localparam int HW   = $clog2(LINE_LEN),
  localparam int WW   = $clog2(WIN),
  localparam int CMAX = (WIN - 1 > FIXED_PEN) ? WIN - 1 : FIXED_PEN,
  localparam int CW   = $clog2(CMAX + 1),
  localparam int PRW  = $clog2(LEAD + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_start,
  input  logic [1:0]       cyc_kind,
  input  logic [AW-1:0]    cyc_addr,
  input  logic [PAGES-1:0] vpage_mask,
  input  logic [1:0]       wait_mode,
  output logic             wait_n
);

  logic [HW-1:0]  hpos;
  logic [WW-1:0]  phase;
  logic           is_vid;
  logic [CW-1:0]  fix_len;
  logic           take;
  logic [CW-1:0]  cnt;
  logic [PRW-1:0] pre;
  logic           vid_active;
  logic           busy;

  wsg_hcount #(.LINE_LEN(LINE_LEN), .WIN(WIN)) u_hc (
    .clk   (clk),
    .rst_n (rst_n),
    .hpos  (hpos),
    .phase (phase)
  );

  wsg_classify #(
    .AW(AW), .PAGES(PAGES), .FIXED_PEN(FIXED_PEN), .CW(CW)
  ) u_cls (
    .kind    (cyc_kind),
    .addr    (cyc_addr),
    .vmask   (vpage_mask),
    .mode    (wait_mode),
    .is_vid  (is_vid),
    .fix_len (fix_len)
  );

  // One request per bus cycle: a strobe during a stall is dropped.
  assign take = cyc_start && !busy;

  wsg_stall_ctr #(.WIN(WIN), .LEAD(LEAD), .CW(CW)) u_sc (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .take_vid   (is_vid),
    .fix_len    (fix_len),
    .phase      (phase),
    .cnt        (cnt),
    .pre        (pre),
    .vid_active (vid_active),
    .busy       (busy),
    .wait_n     (wait_n)
  );

endmodule

// File: rtl/wsg_chk.sv
module wsg_chk #(
  parameter int LINE_LEN  = 912,
  parameter int FIXED_PEN = 2,
  parameter int HW  = 10,
  parameter int WW  = 4,
  parameter int CW  = 4,
  parameter int PRW = 2
) (
  input logic           clk,
  input logic           rst_n,
  input logic           cyc_start,
  input logic           wait_n,
  input logic [HW-1:0]  hpos,
  input logic [WW-1:0]  phase,
  input logic [CW-1:0]  cnt,
  input logic [PRW-1:0] pre,
  input logic           vid_active,
  input logic           busy
);

  // R7
  hpos_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hpos < HW'(LINE_LEN));

  // R7
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (phase - $past(phase)) == WW'(1));

  // R6
  vid_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(wait_n) && vid_active) |-> phase == '0);

  // R5
  fix_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!vid_active && !wait_n) |-> cnt <= CW'(FIXED_PEN));

  // R9
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_start && busy && pre == '0 && cnt != '0) |=> cnt == $past(cnt) - CW'(1));

  // R6
  lead_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pre != '0) |-> wait_n);

endmodule

bind wsg_top wsg_chk #(
  .LINE_LEN(LINE_LEN), .FIXED_PEN(FIXED_PEN),
  .HW(HW), .WW(WW), .CW(CW), .PRW(PRW)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cyc_start  (cyc_start),
  .wait_n     (wait_n),
  .hpos       (hpos),
  .phase      (phase),
  .cnt        (cnt),
  .pre        (pre),
  .vid_active (vid_active),
  .busy       (busy)
);

// File: tb/sim_wsg_top.sv
module sim_wsg_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_start = 1'b0;
  logic [1:0]  cyc_kind = 2'd0;
  logic [15:0] cyc_addr = 16'h0000;
  logic [3:0]  vpage_mask = 4'b0000;
  logic [1:0]  wait_mode = 2'd0;
  logic        wait_n;

  int n_chk = 0;
  int n_bad = 0;
  int cyc_b = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc_b <= cyc_b + 1;

  wsg_top u0 (
    .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .cyc_kind(cyc_kind),
    .cyc_addr(cyc_addr), .vpage_mask(vpage_mask), .wait_mode(wait_mode),
    .wait_n(wait_n)
  );

  task automatic check(bit ok, string tag, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int vid_len(int h0);
    int p;
    p = (h0 + 3) % 912 % 16;
    return (16 - p) % 16;
  endfunction

  task automatic wait_phase(int p);
    @(negedge clk);
    while (cyc_b % 16 != p) @(negedge clk);
  endtask

  // Called at a negedge; drives one strobe and measures the resulting wait.
  task automatic run_access(logic [1:0] kind, logic [15:0] addr, bit vid,
                            int fixlen, string tag);
    int h0, n, first, e_len, e_first;
    cyc_kind = kind; cyc_addr = addr; cyc_start = 1'b1;
    h0 = cyc_b;
    @(negedge clk);
    cyc_start = 1'b0;
    n = 0; first = 0;
    for (int i = 1; i <= 24; i++) begin
      if (!wait_n) begin n++; if (first == 0) first = i; end
      @(negedge clk);
    end
    e_len   = vid ? vid_len(h0) : fixlen;
    e_first = (e_len == 0) ? 0 : (vid ? 3 : 1);
    check(n == e_len, {tag, " length"}, n, e_len);
    check(first == e_first, {tag, " start"}, first, e_first);
  endtask

  task automatic t_reset();
    check(wait_n == 1'b1, "R10 wait high in reset", int'(wait_n), 1);
    @(negedge clk); rst_n = 1'b1;
    check(wait_n == 1'b1, "R10 wait high after reset", int'(wait_n), 1);
  endtask

  task automatic t_fixed();
    vpage_mask = 4'b0000;
    wait_mode = 2'd2; run_access(2'd0, 16'h1234, 0, 2, "R3 read mode2");
    wait_mode = 2'd1; run_access(2'd0, 16'h1234, 0, 0, "R3 read mode1");
    wait_mode = 2'd2; run_access(2'd1, 16'h4321, 0, 2, "R3 R5 write mode2");
    wait_mode = 2'd0; run_access(2'd1, 16'h4321, 0, 0, "R3 write mode0");
    wait_mode = 2'd3; run_access(2'd0, 16'hF000, 0, 2, "R2 read mode3");
    wait_mode = 2'd1; run_access(2'd2, 16'h0100, 0, 2, "R4 opfetch mode1");
    wait_mode = 2'd0; run_access(2'd2, 16'h0100, 0, 0, "R4 opfetch mode0");
    wait_mode = 2'd2; run_access(2'd2, 16'h0100, 0, 2, "R4 opfetch mode2");
  endtask

  task automatic t_pages();
    vpage_mask = 4'b0100; wait_mode = 2'd0;
    wait_phase(4);  run_access(2'd0, 16'h8000, 1, 0, "R1 video page read");
    run_access(2'd0, 16'hC000, 0, 0, "R1 plain page read");
    wait_mode = 2'd2;
    run_access(2'd1, 16'h4000, 0, 2, "R1 page1 not video");
    vpage_mask = 4'b1000;
    wait_phase(7);  run_access(2'd2, 16'hC123, 1, 0, "R1 video opfetch");
  endtask

  task automatic t_phases();
    vpage_mask = 4'b0001; wait_mode = 2'd2;
    wait_phase(13); run_access(2'd0, 16'h0040, 1, 0, "R6 phase0 no wait");
    wait_phase(14); run_access(2'd0, 16'h0040, 1, 0, "R6 phase1 wait15");
    wait_phase(12); run_access(2'd1, 16'h0040, 1, 0, "R6 phase15 wait1");
  endtask

  task automatic t_io();
    vpage_mask = 4'b1111; wait_mode = 2'd2;
    wait_phase(2);  run_access(2'd3, 16'h0085, 1, 0, "R8 video port");
    run_access(2'd3, 16'h0095, 0, 0, "R8 other port");
    run_access(2'd3, 16'h8010, 0, 0, "R8 port high addr");
  endtask

  task automatic t_wrap();
    vpage_mask = 4'b0010; wait_mode = 2'd0;
    while (cyc_b < 920) @(negedge clk);
    wait_phase(5); run_access(2'd0, 16'h4ABC, 1, 0, "R7 after line wrap");
  endtask

  task automatic t_ignore();
    int n;
    vpage_mask = 4'b0000; wait_mode = 2'd2;
    cyc_kind = 2'd0; cyc_addr = 16'h1000; cyc_start = 1'b1;
    @(negedge clk);
    cyc_kind = 2'd3; cyc_addr = 16'h0080;
    @(negedge clk);
    cyc_start = 1'b0;
    n = 1;
    for (int i = 2; i <= 30; i++) begin
      if (!wait_n) n++;
      @(negedge clk);
    end
    check(n == 2, "R9 strobe during fixed stall", n, 2);
    vpage_mask = 4'b0001;
    wait_phase(6);
    begin
      int h0, m, e;
      h0 = cyc_b;
      cyc_kind = 2'd0; cyc_addr = 16'h0200; cyc_start = 1'b1;
      @(negedge clk);
      cyc_kind = 2'd2; cyc_addr = 16'h8000;
      @(negedge clk);
      cyc_start = 1'b0;
      m = 0;
      for (int i = 2; i <= 30; i++) begin
        if (!wait_n) m++;
        @(negedge clk);
      end
      e = vid_len(h0);
      check(m == e, "R9 strobe during video lead", m, e);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    repeat (2) @(negedge clk);
    t_fixed();
    t_pages();
    t_phases();
    t_io();
    t_ignore();
    t_wrap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule